// File: doc/BRIEF.md
# VCO Clock Divider with Control Register

This block turns one fast VCO clock into three derived clocks: a system clock, a display pixel clock and an external clock-output pin. A 16-bit control register, written and read through a plain single-word port, sets the ratio of each of the two divided clocks on its own. Each clock can run at the VCO rate or at 1/2, 1/4, 1/8 or 1/16 of it. Software may pick a new ratio at any moment. The new ratio is applied only at an instant when every divided clock is low, so no output ever carries a shortened pulse. The VCO itself is never touched.

The register also holds a clock-output enable and a shutdown bit. Writing the shutdown bit stops all three derived clocks, which leaves only the slow low-power clock (not part of this block) running. Software cannot clear the shutdown bit. It clears only on a wake-up pulse or on reset, and the clocks then restart at whatever ratios the register holds at that time.

The register port is a control path, not a data stream. It has no valid/ready handshake: a write is taken on every VCO rising edge where the write strobe is high, and the read word is always available. Because nothing flows with back-pressure, there are no rules for holding off.

Top module: `vco_clkdiv_ctrl`

## Requirements
- R1: Each 3-bit ratio field selects: 000 → VCO/2, 001 → VCO/4, 010 → VCO/8, 011 → VCO/16, and any value with bit 2 set → VCO/1. The output period is exactly that many VCO periods.
- R2: While reset is low, the read word is 0x2410 and all three clocks are low. After reset both ratio fields read 100, so both clocks run at VCO/1.
- R3: Read word layout: pixel ratio in bits 13:11, system ratio in bits 10:8, clock-output enable in bit 4, shutdown in bit 3. Every other bit reads 0 and ignores writes.
- R4: A written ratio takes effect within 16 VCO cycles, at a point where old and new clocks are both low. No output high or low phase is ever shorter than half a VCO period.
- R5: With bit 4 = 1 the clock-output pin carries the system clock. With bit 4 = 0 it stays low.
- R6: Writing bit 3 = 1 sets shutdown. Within 16 VCO cycles the system, pixel and clock-output pins stop low and remain low.
- R7: While shut down, a write with bit 3 = 0 leaves bit 3 at 1 and the clocks stopped. The ratio and enable fields of that write are still stored.
- R8: A one-cycle pulse on wake_i clears bit 3 on the next VCO edge. The clocks then restart from a low phase at the ratios held in the register.
- R9: The pixel and system ratios are independent. Changing one does not alter the period of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast VCO clock; all logic runs from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the VCO rising edge |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Current register contents |
| wake_i | input | 1 | Wake-up pulse that clears shutdown |
| sys_clk_o | output | 1 | Divided system clock |
| pix_clk_o | output | 1 | Divided pixel clock |
| clk_out_o | output | 1 | External clock pin, system clock when enabled |

## Verification
Register writes and the wake pulse show on the read word one VCO edge after they are taken. The bench therefore reads back on the falling edge that follows. A ratio, enable or shutdown change reaches the clock pins only at the next all-low point of the 16-cycle phase counter, so at most 16 cycles later. Every clock measurement begins only after a 40-cycle settle and then counts edges over a 128-cycle window, taking the period from the last two rising edges. Pulse widths are watched on every output for the whole run, so a runt at any reselection counts as a miscompare.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = 3;
  localparam int TAPS     = 1 << (SEL_W - 1);
  localparam int PIX_LSB  = 11;
  localparam int SYS_LSB  = 8;
  localparam int CKEN_BIT = 4;
  localparam int HALT_BIT = 3;
  localparam logic [SEL_W-1:0] SEL_BYPASS = SEL_W'(1) << (SEL_W - 1);

  typedef struct packed {
    logic [SEL_W-1:0] pix_sel;
    logic [SEL_W-1:0] sys_sel;
    logic             cken;
    logic             halt;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pix_sel: SEL_BYPASS, sys_sel: SEL_BYPASS,
                                 cken: 1'b1, halt: 1'b0};

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PIX_LSB +: SEL_W] = c.pix_sel;
    w[SYS_LSB +: SEL_W] = c.sys_sel;
    w[CKEN_BIT]         = c.cken;
    w[HALT_BIT]         = c.halt;
    return w;
  endfunction
endpackage

// File: rtl/vcd_phase_cnt.sv
module vcd_phase_cnt #(
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] cnt_nxt,
  output logic            wrap
);
  logic [TAPS-1:0] cnt_q;

  assign cnt_nxt = cnt_q + TAPS'(1);
  assign wrap    = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/vcd_clk_channel.sv
module vcd_clk_channel #(
  parameter int SEL_W = 3,
  parameter int TAPS  = 1 << (SEL_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  input  logic [TAPS-1:0]  cnt_nxt,
  input  logic             wrap,
  output logic             clk_o
);
  localparam int IDX_W = SEL_W - 1;
  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(1) << (SEL_W - 1);

  logic [SEL_W-1:0] act_sel;
  logic             act_run;
  logic [SEL_W-1:0] sel_eff;
  logic             run_eff;
  logic             div_q;
  logic             pass_q;
  logic [IDX_W-1:0] tap_idx;

  // settings are swapped only at the all-low point of the phase counter
  assign sel_eff = wrap ? sel : act_sel;
  assign run_eff = wrap ? run : act_run;
  assign tap_idx = sel_eff[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= SEL_RST;
      act_run <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      act_sel <= sel_eff;
      act_run <= run_eff;
      div_q   <= run_eff & ~sel_eff[SEL_W-1] & cnt_nxt[tap_idx];
    end
  end

  // bypass enable moves only while the VCO is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= act_run & act_sel[SEL_W-1];
  end

  assign clk_o = div_q | (clk & pass_q);
endmodule

// File: rtl/vcd_ctrl_reg.sv
module vcd_ctrl_reg
  import vcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wake_i,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rd_data
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else begin
      if (wr_en) begin
        ctrl_q.pix_sel <= wr_data[PIX_LSB +: SEL_W];
        ctrl_q.sys_sel <= wr_data[SYS_LSB +: SEL_W];
        ctrl_q.cken    <= wr_data[CKEN_BIT];
      end
      if (wake_i)
        ctrl_q.halt <= 1'b0;
      else if (wr_en && wr_data[HALT_BIT])
        ctrl_q.halt <= 1'b1;
    end
  end

  assign ctrl    = ctrl_q;
  assign rd_data = ctrl_pack(ctrl_q);
endmodule

// File: rtl/vco_clkdiv_ctrl.sv
module vco_clkdiv_ctrl
  import vcd_pkg::*;
(
  input  logic              clk_vco,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wake_i,
  output logic              sys_clk_o,
  output logic              pix_clk_o,
  output logic              clk_out_o
);
  localparam int NCH = 3;

  ctrl_t               ctrl;
  logic [TAPS-1:0]     cnt_nxt;
  logic                wrap;
  logic [SEL_W-1:0]    ch_sel [NCH];
  logic [NCH-1:0]      ch_run;
  logic [NCH-1:0]      ch_clk;

  vcd_ctrl_reg u_reg (
    .clk(clk_vco), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wake_i(wake_i), .ctrl(ctrl), .rd_data(rd_data)
  );

  vcd_phase_cnt #(.TAPS(TAPS)) u_cnt (
    .clk(clk_vco), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  // channel 0: system, 1: pixel, 2: external pin (system ratio)
  assign ch_sel[0] = ctrl.sys_sel;
  assign ch_sel[1] = ctrl.pix_sel;
  assign ch_sel[2] = ctrl.sys_sel;
  assign ch_run[0] = ~ctrl.halt;
  assign ch_run[1] = ~ctrl.halt;
  assign ch_run[2] = ~ctrl.halt & ctrl.cken;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    vcd_clk_channel #(.SEL_W(SEL_W), .TAPS(TAPS)) u_ch (
      .clk(clk_vco), .rst_n(rst_n), .sel(ch_sel[g]), .run(ch_run[g]),
      .cnt_nxt(cnt_nxt), .wrap(wrap), .clk_o(ch_clk[g])
    );
  end

  assign sys_clk_o = ch_clk[0];
  assign pix_clk_o = ch_clk[1];
  assign clk_out_o = ch_clk[2];
endmodule

// File: rtl/vcd_chk.sv
module vcd_chk
  import vcd_pkg::*;
(
  input logic              clk_vco,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              wake_i,
  input logic              sys_clk_o,
  input logic              pix_clk_o,
  input logic              clk_out_o
);
  localparam logic [DATA_W-1:0] USED = ctrl_pack('{pix_sel: '1, sys_sel: '1, cken: 1'b1, halt: 1'b1});
  logic [5:0] halt_cyc;

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n)              halt_cyc <= '0;
    else if (!rd_data[HALT_BIT]) halt_cyc <= '0;
    else if (halt_cyc != 6'd63) halt_cyc <= halt_cyc + 6'd1;
  end

  // R3
  unused_bits_zero_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (rd_data & ~USED) == '0);
  // R7
  halt_sticky_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (rd_data[HALT_BIT] && !wake_i) |=> rd_data[HALT_BIT]);
  // R8
  wake_clears_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    wake_i |=> !rd_data[HALT_BIT]);
  // R6
  halted_quiet_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (halt_cyc >= 6'd18) |-> (!sys_clk_o && !pix_clk_o && !clk_out_o));
  // R5
  pin_follows_sys_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    clk_out_o |-> sys_clk_o);
  // R6
  halt_set_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (wr_en && wr_data[HALT_BIT] && !wake_i) |=> rd_data[HALT_BIT]);
endmodule

bind vco_clkdiv_ctrl vcd_chk chk_i (
  .clk_vco(clk_vco), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .wake_i(wake_i), .sys_clk_o(sys_clk_o),
  .pix_clk_o(pix_clk_o), .clk_out_o(clk_out_o)
);

// File: tb/vco_clkdiv_ctrl_tb_top.sv
`timescale 1ns/1ps
module vcd_edge_mon (input logic sig);
  int  rises  = 0;
  int  narrow = 0;
  real last_t = -1.0;
  real last_r = 0.0;
  real prev_r = 0.0;

  always @(sig) begin
    if (last_t > 0.0 && ($realtime - last_t) < 3.5) narrow++;
    last_t = $realtime;
    if (sig === 1'b1) begin
      prev_r = last_r;
      last_r = $realtime;
      rises++;
    end
  end
endmodule

module vco_clkdiv_ctrl_tb_top;
  logic        clk_vco = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wake_i  = 1'b0;
  logic [15:0] rd_data;
  logic        sys_clk_o, pix_clk_o, clk_out_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk_vco = ~clk_vco;

  vco_clkdiv_ctrl dut_i (
    .clk_vco(clk_vco), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wake_i(wake_i), .sys_clk_o(sys_clk_o),
    .pix_clk_o(pix_clk_o), .clk_out_o(clk_out_o)
  );

  vcd_edge_mon mon_sys (.sig(sys_clk_o));
  vcd_edge_mon mon_pix (.sig(pix_clk_o));
  vcd_edge_mon mon_pin (.sig(clk_out_o));

  function automatic int ratio(logic [2:0] s);
    return s[2] ? 1 : (2 << s[1:0]);
  endfunction

  function automatic logic [15:0] word(logic [2:0] p, logic [2:0] s, logic ck, logic h);
    return {2'b00, p, s, 3'b000, ck, h, 3'b000};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk_vco);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk_vco);
    wr_en = 1'b0;
  endtask

  task automatic settle_and_window();
    repeat (40) @(negedge clk_vco);
    mon_sys.rises = 0; mon_pix.rises = 0; mon_pin.rises = 0;
    repeat (128) @(negedge clk_vco);
  endtask

  function automatic int per_ps(real a, real b);
    return int'((a - b) * 1000.0);
  endfunction

  task automatic chk_periods(string rs, string rp, logic [2:0] ss, logic [2:0] ps);
    chk(mon_sys.rises > 0 && per_ps(mon_sys.last_r, mon_sys.prev_r) == ratio(ss) * 8000,
        rs, "system period ps", per_ps(mon_sys.last_r, mon_sys.prev_r), ratio(ss) * 8000);
    chk(mon_pix.rises > 0 && per_ps(mon_pix.last_r, mon_pix.prev_r) == ratio(ps) * 8000,
        rp, "pixel period ps", per_ps(mon_pix.last_r, mon_pix.prev_r), ratio(ps) * 8000);
  endtask

  initial begin
    logic [2:0] ss, ps;
    logic       ck;
    int         seed;
    seed = $urandom(32'h5EED_0042);
    // R2: reset state
    repeat (3) @(negedge clk_vco);
    chk(rd_data == 16'h2410, "R2", "reset read word", rd_data, 16'h2410);
    chk({sys_clk_o, pix_clk_o, clk_out_o} == 3'b000, "R2", "clocks in reset",
        {sys_clk_o, pix_clk_o, clk_out_o}, 0);
    rst_n = 1'b1;
    settle_and_window();
    chk_periods("R2", "R2", 3'b100, 3'b100);
    chk(mon_pin.rises == mon_sys.rises, "R5", "pin edges after reset", mon_pin.rises, mon_sys.rises);

    // R3: unused bits ignore writes and read zero
    wr(16'hC0E7);
    @(negedge clk_vco);
    chk(rd_data == 16'h0000, "R3", "unused bits", rd_data, 0);
    wr(word(3'b100, 3'b100, 1'b1, 1'b0));
    @(negedge clk_vco);
    chk(rd_data == 16'h2410, "R3", "field layout", rd_data, 16'h2410);

    // R1 / R9: every encoding, system and pixel crossed
    for (int e = 0; e < 8; e++) begin
      ss = 3'(e); ps = 3'(7 - e);
      wr(word(ps, ss, 1'b1, 1'b0));
      settle_and_window();
      chk_periods("R1", "R9", ss, ps);
    end

    // R4 / R5: random reselection with clock-pin enable
    for (int i = 0; i < 14; i++) begin
      ss = 3'($urandom); ps = 3'($urandom); ck = 1'($urandom);
      wr(word(ps, ss, ck, 1'b0));
      settle_and_window();
      chk_periods("R4", "R9", ss, ps);
      if (ck)
        chk(per_ps(mon_pin.last_r, mon_pin.prev_r) == ratio(ss) * 8000 && mon_pin.rises > 0,
            "R5", "pin period ps", per_ps(mon_pin.last_r, mon_pin.prev_r), ratio(ss) * 8000);
      else
        chk(mon_pin.rises == 0, "R5", "pin edges when disabled", mon_pin.rises, 0);
    end

    // R6: shutdown
    wr(word(3'b010, 3'b001, 1'b1, 1'b1));
    @(negedge clk_vco);
    chk(rd_data[3] == 1'b1, "R6", "shutdown bit", rd_data[3], 1);
    settle_and_window();
    chk(mon_sys.rises + mon_pix.rises + mon_pin.rises == 0, "R6", "edges while shut down",
        mon_sys.rises + mon_pix.rises + mon_pin.rises, 0);

    // R7: software clear ignored, other fields stored
    wr(word(3'b011, 3'b000, 1'b1, 1'b0));
    @(negedge clk_vco);
    chk(rd_data == (word(3'b011, 3'b000, 1'b1, 1'b1)), "R7", "read after clear attempt",
        rd_data, word(3'b011, 3'b000, 1'b1, 1'b1));
    settle_and_window();
    chk(mon_sys.rises + mon_pix.rises + mon_pin.rises == 0, "R7", "edges after clear attempt",
        mon_sys.rises + mon_pix.rises + mon_pin.rises, 0);

    // R8: wake restarts at stored ratios
    @(negedge clk_vco); wake_i = 1'b1;
    @(negedge clk_vco); wake_i = 1'b0;
    chk(rd_data[3] == 1'b0, "R8", "shutdown cleared by wake", rd_data[3], 0);
    settle_and_window();
    chk_periods("R8", "R8", 3'b000, 3'b011);
    chk(mon_pin.rises == mon_sys.rises, "R8", "pin restarted", mon_pin.rises, mon_sys.rises);

    // R4: no runt phase anywhere in the run
    chk(mon_sys.narrow + mon_pix.narrow + mon_pin.narrow == 0, "R4", "narrow phases",
        mon_sys.narrow + mon_pix.narrow + mon_pin.narrow, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_vco);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule